// File: doc/BRIEF.md
# Collision and Heartbeat Indicator

This block produces the collision signal that a PHY hands to its MAC. The datapath supplies two activity flags, one for transmit and one for receive, together with the link's speed, its duplex setting and a heartbeat enable. In half duplex, at either 10 or 100 Mb/s, the output rises whenever both directions are active in the same cycle. The same indication serves every 10 Mb/s MAC interface form, including the single-bit serial one.

In 10 Mb/s half duplex with the heartbeat enabled, the block also emits a signal-quality-test pulse of about one microsecond each time a transmission finishes. The pulse length is the parameter `CYC_PER_US`, which gives the number of clock cycles in one microsecond. A new transmission cuts the pulse short. No pulse follows a transmission that ended while a real collision was in progress. In full duplex the output stays low at all times.

Top module: `col_hb_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `col_out` is 0 after that edge. A transmit that was active during reset does not start a heartbeat when reset is released.
- R2: In half duplex (`full_dup`=0) at either speed (`speed_100`=0 is 10 Mb/s, 1 is 100 Mb/s), `col_out` is 1 after every edge that samples `tx_act`=1 and `rx_act`=1. When only one of the two flags is set and no heartbeat is running, `col_out` is 0.
- R3: After any edge that samples `full_dup`=1, `col_out` is 0, whatever the activity flags are.
- R4: In 10 Mb/s half duplex with `hb_en`=1, the first edge that samples `tx_act`=0 after a cycle with `tx_act`=1 starts a heartbeat. `col_out` is then 1 after that edge and after the next `CYC_PER_US`-1 edges, which is exactly `CYC_PER_US` cycles, and 0 after that.
- R5: In 10 Mb/s full duplex, the end of a transmission produces no heartbeat.
- R6: At 100 Mb/s, or with `hb_en`=0, the end of a transmission produces no heartbeat.
- R7: An edge that samples `tx_act`=1 during a heartbeat ends it. `col_out` is 0 after that edge unless `rx_act` is also 1.
- R8: When `tx_act` and `rx_act` were both 1 in the last cycle before transmit ended, no heartbeat follows. If the receive activity had already ended before transmit ended, the heartbeat occurs as usual.
- R9: If the link leaves 10 Mb/s half duplex, or `hb_en` drops, while a heartbeat is running, the heartbeat is cancelled. Returning to the heartbeat mode does not bring it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_act | input | 1 | Transmit activity from the datapath |
| rx_act | input | 1 | Receive activity from the datapath |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| hb_en | input | 1 | Heartbeat enable |
| col_out | output | 1 | Registered collision / heartbeat indication |

## Verification
The bench builds the block with `CYC_PER_US` = 4, so each heartbeat lasts four cycles. At that length the pulse's start edge, its last high cycle and its return to low all fall within a short directed sequence. The small count also lets the bench cut a pulse short after two cycles, start a second, complete pulse straight after it, and switch the mode while a pulse is running, all within a few dozen cycles. The default of 25 only stretches the same counter and adds no separate path.

// File: rtl/col_pkg.sv
// Shared types for the collision / heartbeat indicator.
// Assumes the link mode is fully given by the speed and duplex selects.
package col_pkg;

    typedef enum logic [1:0] {
        LM_10_HALF  = 2'd0,
        LM_10_FULL  = 2'd1,
        LM_100_HALF = 2'd2,
        LM_100_FULL = 2'd3
    } link_mode_e;

    // Map the speed and duplex selects onto a link mode.
    function automatic link_mode_e to_mode(input logic spd100, input logic fdx);
        return link_mode_e'({spd100, fdx});
    endfunction

    // The heartbeat exists only in 10 Mb/s half duplex, and only when enabled.
    function automatic logic hb_allowed(input link_mode_e m, input logic en);
        return en && (m == LM_10_HALF);
    endfunction

endpackage

// File: rtl/col_edge.sv
// Tracks the end of a transmission and whether a genuine collision was
// present in the last cycle that transmit was active.
// Assumes tx_act and rx_act are synchronous to clk.
module col_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_act,
    input  logic rx_act,
    input  logic full_dup,
    output logic tx_fall,
    output logic col_at_end
);

    logic tx_q;
    logic col_q;

    // Remember last cycle's transmit flag and collision condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= 1'b0;
            col_q <= 1'b0;
        end else begin
            tx_q  <= tx_act;
            col_q <= tx_act && rx_act && !full_dup;
        end
    end

    // Transmit was active last cycle and is idle now.
    always_comb begin
        tx_fall    = tx_q && !tx_act;
        col_at_end = col_q;
    end

    // R8: a collision flagged at the end of transmit needs transmit to have been active.
    a_r8_end_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
        col_at_end |-> $past(tx_act));

endmodule

// File: rtl/col_hb_timer.sv
// Down-counter that times the signal-quality-test pulse after a transmit.
// It loads when transmit ends and clears when transmit restarts or the
// mode stops allowing the heartbeat. Assumes CYC_PER_US >= 1.
module col_hb_timer
    import col_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_act,
    input  logic       tx_fall,
    input  logic       col_at_end,
    input  link_mode_e mode,
    input  logic       hb_en,
    output logic       hb_next
);

    localparam int unsigned CW = $clog2(CYC_PER_US + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYC_PER_US);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          allowed;

    // Next counter value: clear, load on transmit end, or count down.
    always_comb begin
        allowed = hb_allowed(mode, hb_en);
        if (!allowed || tx_act)
            cnt_nxt = '0;
        else if (tx_fall && !col_at_end)
            cnt_nxt = LOAD;
        else if (cnt != '0)
            cnt_nxt = cnt - 1'b1;
        else
            cnt_nxt = '0;
        hb_next = (cnt_nxt != '0);
    end

    // Hold the remaining pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    // R4: the count never exceeds one microsecond.
    a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);

    // R4: a clean transmit end in the heartbeat mode loads the full length.
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fall && !col_at_end && hb_en && mode == LM_10_HALF) |=> cnt == LOAD);

    // R7: an active transmit leaves no pulse running.
    a_r7_tx_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tx_act |=> cnt == '0);

    // R8: a collision at transmit end suppresses the pulse.
    a_r8_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fall && col_at_end) |=> cnt == '0);

    // R5: outside 10 Mb/s half duplex with heartbeat enabled, no pulse runs.
    a_r5_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != LM_10_HALF || !hb_en) |=> cnt == '0);

endmodule

// File: rtl/col_hb_gen.sv
// Collision output towards the MAC: simultaneous transmit and receive in
// half duplex, plus a one-microsecond heartbeat after each transmit in
// 10 Mb/s half duplex. Held low in full duplex. Output is registered;
// synchronous active-low reset. Assumes all inputs are synchronous to clk.
module col_hb_gen
    import col_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_act,
    input  logic rx_act,
    input  logic speed_100,
    input  logic full_dup,
    input  logic hb_en,
    output logic col_out
);

    link_mode_e mode;
    logic       tx_fall;
    logic       col_at_end;
    logic       hb_next;
    logic       raw_col;

    // Decode the link mode and the plain collision condition.
    always_comb begin
        mode    = to_mode(speed_100, full_dup);
        raw_col = tx_act && rx_act;
    end

    col_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_act     (tx_act),
        .rx_act     (rx_act),
        .full_dup   (full_dup),
        .tx_fall    (tx_fall),
        .col_at_end (col_at_end)
    );

    col_hb_timer #(
        .CYC_PER_US (CYC_PER_US)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_act     (tx_act),
        .tx_fall    (tx_fall),
        .col_at_end (col_at_end),
        .mode       (mode),
        .hb_en      (hb_en),
        .hb_next    (hb_next)
    );

    // Register the merged collision / heartbeat output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col_out <= 1'b0;
        else
            col_out <= !full_dup && (raw_col || hb_next);
    end

    // R1: reset leaves the output low.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !col_out);

    // R2: both directions active in half duplex raise the output.
    a_r2_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_dup && tx_act && rx_act) |=> col_out);

    // R3: full duplex keeps the output low.
    a_r3_fdx_low: assert property (@(posedge clk) disable iff (!rst_n)
        full_dup |=> !col_out);

    // R6: at 100 Mb/s the output follows only the collision condition.
    a_r6_fast_no_hb: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && !(tx_act && rx_act)) |=> !col_out);

endmodule

// File: tb/sim_col_hb_gen.sv
`timescale 1ns/1ps
module sim_col_hb_gen;

    localparam int unsigned N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_act = 1'b0;
    logic rx_act = 1'b0;
    logic speed_100 = 1'b0;
    logic full_dup = 1'b0;
    logic hb_en = 1'b0;
    logic col_out;

    logic m_rst = 1'b0, m_spd = 1'b0, m_fdx = 1'b0, m_hb = 1'b0;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    bit   exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    col_hb_gen #(.CYC_PER_US(N)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
        .speed_100(speed_100), .full_dup(full_dup), .hb_en(hb_en),
        .col_out(col_out)
    );

    // Driver: apply one cycle of inputs and queue the output expected after the next edge.
    task automatic step(input bit tx, input bit rx, input bit exp, input string tag);
        @(negedge clk);
        rst_n     = m_rst;
        speed_100 = m_spd;
        full_dup  = m_fdx;
        hb_en     = m_hb;
        tx_act    = tx;
        rx_act    = rx;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if (col_out !== e) begin
                    n_bad++;
                    $display("FAIL %s: col_out=%b expected=%b at %0t", t, col_out, e, $time);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset, including transmit and receive active during reset
        m_rst = 0;
        step(0, 0, 0, "R1");
        step(1, 1, 0, "R1");
        step(1, 0, 0, "R1");
        m_rst = 1; m_spd = 0; m_fdx = 0; m_hb = 1;
        step(0, 0, 0, "R1 no heartbeat after reset");
        step(0, 0, 0, "R1");

        // R2 / R6: 10 Mb/s half duplex, heartbeat disabled
        m_hb = 0;
        step(1, 0, 0, "R2 tx alone");
        step(1, 1, 1, "R2");
        step(0, 1, 0, "R6 hb_en=0");
        step(0, 0, 0, "R6 hb_en=0");

        // R2 / R6: 100 Mb/s half duplex, heartbeat enabled
        m_spd = 1; m_hb = 1;
        step(1, 1, 1, "R2 100M");
        step(1, 0, 0, "R2 100M");
        step(0, 0, 0, "R6 100M");
        step(0, 0, 0, "R6 100M");

        // R3: full duplex at 100 Mb/s
        m_fdx = 1;
        step(1, 1, 0, "R3");
        step(1, 1, 0, "R3");
        step(0, 0, 0, "R3");

        // R4: heartbeat in 10 Mb/s half duplex
        m_spd = 0; m_fdx = 0;
        step(0, 1, 0, "R2 rx alone");
        step(1, 0, 0, "R4");
        step(1, 0, 0, "R4");
        for (int i = 0; i < N; i++) step(0, 0, 1, "R4 pulse");
        step(0, 0, 0, "R4 pulse end");
        step(0, 0, 0, "R4");

        // R5 / R3: 10 Mb/s full duplex
        m_fdx = 1;
        step(1, 1, 0, "R3 10M");
        step(1, 0, 0, "R5");
        for (int i = 0; i < N + 1; i++) step(0, 0, 0, "R5");

        // R7: new transmit cuts the pulse, then a full pulse follows
        m_fdx = 0;
        step(1, 0, 0, "R7");
        step(0, 0, 1, "R4");
        step(0, 0, 1, "R4");
        step(1, 0, 0, "R7 cut");
        step(1, 0, 0, "R7");
        for (int i = 0; i < N; i++) step(0, 0, 1, "R7 second pulse");
        step(0, 0, 0, "R7");

        // R8: collision at transmit end suppresses the pulse
        step(1, 1, 1, "R2");
        for (int i = 0; i < N + 1; i++) step(0, 0, 0, "R8 suppressed");
        // R8: collision gone before transmit end, pulse occurs
        step(1, 1, 1, "R2");
        step(1, 0, 0, "R8");
        for (int i = 0; i < N; i++) step(0, 0, 1, "R8 pulse");
        step(0, 0, 0, "R8");

        // R9: duplex change cancels a running pulse
        step(1, 0, 0, "R9");
        step(0, 0, 1, "R9");
        step(0, 0, 1, "R9");
        m_fdx = 1;
        step(0, 0, 0, "R9 fdx");
        m_fdx = 0;
        step(0, 0, 0, "R9 not resumed");
        step(0, 0, 0, "R9 not resumed");

        // R9: heartbeat disable cancels a running pulse
        step(1, 0, 0, "R9");
        step(0, 0, 1, "R9");
        m_hb = 0;
        step(0, 0, 0, "R9 hb off");
        m_hb = 1;
        step(0, 0, 0, "R9 not resumed");

        // R1: reset in the middle of a pulse
        step(1, 0, 0, "R1");
        step(0, 0, 1, "R4");
        m_rst = 0;
        step(0, 0, 0, "R1 mid pulse");
        m_rst = 1;
        step(0, 0, 0, "R1");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule